// File: doc/BRIEF.md
# Two-Source Byte Permute Unit

The unit assembles a 128-bit result vector from the bytes of two 128-bit data vectors. The two sources are treated as one pool of 32 bytes, first source then second. Each of the 16 result byte lanes owns a selector byte in a third 128-bit control vector, so every lane picks its own byte from the pool, and the pattern can change from one operation to the next. One byte may go to many lanes, and a byte may go to no lane at all.

The unit takes one operation per cycle under a single valid strobe and has no backpressure. The result goes to a register, so it appears, flagged by its own valid, one clock after the operands were presented. A two-state output stage tracks whether the register holds a fresh result. It has the states ST_EMPTY and ST_FULL. Its transitions are: ST_EMPTY to ST_FULL when an operation is accepted; ST_FULL stays in ST_FULL on a back-to-back operation; ST_FULL goes to ST_EMPTY on a cycle with no operation; ST_EMPTY stays in ST_EMPTY on a cycle with no operation; and any state goes to ST_EMPTY on reset. The result register holds its value while no operation arrives.

Top module: `byte_permute_unit`

## Requirements
- R1: Lanes are numbered big-endian in every vector. Lane i occupies bits [127-8i : 120-8i], so lane 0 is the most significant byte.
- R2: For result lane i, control lane i selects the source. Control bit 4 set to 0 takes source A and set to 1 takes source B. Control bits 3:0 give the lane number within that source.
- R3: Bits 7:5 of every control byte are ignored. Setting them leaves the result unchanged.
- R4: A control vector whose lanes hold 0x00, 0x01, ... 0x0F in lane order returns source A unchanged.
- R5: A control vector whose lanes hold 0x10, 0x11, ... 0x1F in lane order returns source B unchanged.
- R6: Every cycle with in_valid high produces exactly one cycle with out_valid high, on the following clock. Back-to-back operations are all accepted.
- R7: When in_valid is low, out_valid goes low on the next clock and result keeps its previous value.
- R8: A synchronous active-high reset clears out_valid and result to zero.
- R9: One source byte may be steered to several result lanes in the same operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src_a | input | 128 | Data source A (pool bytes 0..15) |
| src_b | input | 128 | Data source B (pool bytes 16..31) |
| ctl | input | 128 | Per-lane selector vector |
| out_valid | output | 1 | Result register holds a result from the previous cycle |
| result | output | 128 | Registered permuted vector |

## Verification
The bench builds the unit with its default parameters, 16 lanes of 8 bits. This gives a 32-byte pool and a 5-bit selector, so every legal selector value and both source halves can be reached. Random control vectors cover arbitrary mixes of A and B. The same random vectors with the ignored upper bits forced high show that those bits have no effect. The 16-lane width also allows full-width reversal and broadcast patterns to be checked lane by lane against an independent reference.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_t;

endpackage

// File: rtl/perm_lane_sel.sv
module perm_lane_sel #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 16
) (
    input  logic [2*LANES*BYTE_W-1:0] pool_vec,
    input  logic [BYTE_W-1:0]         sel_byte,
    output logic [BYTE_W-1:0]         lane_out
);
    localparam int POOL_N = 2 * LANES;
    localparam int POOL_W = POOL_N * BYTE_W;

    logic [BYTE_W-1:0] pool [POOL_N];
    logic [POOL_N-1:0] hit;

    // R1: pool byte k sits at the big-endian position k
    for (genvar k = 0; k < POOL_N; k++) begin : g_pool
        assign pool[k] = pool_vec[POOL_W-1-k*BYTE_W -: BYTE_W];
        // R2, R3: selection is taken modulo the pool size, so the high bits drop out
        assign hit[k]  = ((32'(sel_byte) % POOL_N) == k);
    end

    always_comb begin
        lane_out = '0;
        for (int k = 0; k < POOL_N; k++) begin
            if (hit[k]) begin
                lane_out = lane_out | pool[k];
            end
        end
    end

endmodule

// File: rtl/perm_xbar.sv
module perm_xbar #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 16
) (
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    input  logic [LANES*BYTE_W-1:0] ctl,
    output logic [LANES*BYTE_W-1:0] perm
);
    localparam int VEC_W = LANES * BYTE_W;

    logic [2*VEC_W-1:0] pool_vec;

    assign pool_vec = {src_a, src_b};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        perm_lane_sel #(
            .BYTE_W (BYTE_W),
            .LANES  (LANES)
        ) i_lane (
            .pool_vec (pool_vec),
            .sel_byte (ctl[VEC_W-1-i*BYTE_W -: BYTE_W]),
            .lane_out (perm[VEC_W-1-i*BYTE_W -: BYTE_W])
        );
    end

endmodule

// File: rtl/perm_out_stage.sv
module perm_out_stage
    import perm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] perm_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    stage_state_t state_q;
    stage_state_t state_d;
    logic [VEC_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (in_valid) begin
            data_q <= perm_in;
        end
    end

    assign out_valid = (state_q == ST_FULL);
    assign result    = data_q;

    // R6
    latency_one_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && (result == '0)));

endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    input  logic [LANES*BYTE_W-1:0] ctl,
    output logic                    out_valid,
    output logic [LANES*BYTE_W-1:0] result
);
    localparam int VEC_W = LANES * BYTE_W;

    logic [VEC_W-1:0] perm;
    logic [VEC_W-1:0] ident_a;
    logic [VEC_W-1:0] ident_b;

    perm_xbar #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) i_xbar (
        .src_a (src_a),
        .src_b (src_b),
        .ctl   (ctl),
        .perm  (perm)
    );

    perm_out_stage #(
        .VEC_W (VEC_W)
    ) i_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .perm_in   (perm),
        .out_valid (out_valid),
        .result    (result)
    );

    // identity selector patterns, used only by the checks below
    for (genvar i = 0; i < LANES; i++) begin : g_ident
        assign ident_a[VEC_W-1-i*BYTE_W -: BYTE_W] = BYTE_W'(i);
        assign ident_b[VEC_W-1-i*BYTE_W -: BYTE_W] = BYTE_W'(LANES + i);
    end

    // R4
    ident_a_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl == ident_a) |=> (result == $past(src_a)));

    // R5
    ident_b_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl == ident_b) |=> (result == $past(src_b)));

endmodule

// File: tb/test_byte_permute_unit.sv
module test_byte_permute_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] ctl = '0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [127:0] exp_q [$];
    string        tag_q [$];
    logic [127:0] last_exp = '0;

    always #5 clk = ~clk;

    byte_permute_unit i_byte_permute_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .ctl       (ctl),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [127:0] ref_perm(logic [127:0] a, logic [127:0] b, logic [127:0] c);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            int sel = int'(c[127-8*i -: 8]) & 31;
            int idx = sel & 15;
            if (sel < 16) r[127-8*i -: 8] = a[127-8*idx -: 8];
            else          r[127-8*i -: 8] = b[127-8*idx -: 8];
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    function automatic logic [127:0] fill_ctl(int base, int step);
        logic [127:0] c = '0;
        for (int i = 0; i < 16; i++) c[127-8*i -: 8] = 8'(base + step * i);
        return c;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: called at a falling edge, leaves at the next falling edge
    task automatic send(logic [127:0] a, logic [127:0] b, logic [127:0] c, string tag);
        src_a    = a;
        src_b    = b;
        ctl      = c;
        in_valid = 1'b1;
        exp_q.push_back(ref_perm(a, b, c));
        tag_q.push_back(tag);
        last_exp = ref_perm(a, b, c);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R6: out_valid 1 with no pending item, expected 0");
            end else begin
                check(tag_q.pop_front(), result, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] c;

        repeat (3) @(negedge clk);
        // R8: state after reset
        check("R8 reset out_valid", 128'(out_valid), 128'(0));
        check("R8 reset result", result, '0);
        rst = 1'b0;
        @(negedge clk);

        a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        b = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

        // R4 and R5: identities
        send(a, b, fill_ctl(0, 1), "R4 identity A");
        send(a, b, fill_ctl(16, 1), "R5 identity B");
        // R1: full reversal of A
        send(a, b, fill_ctl(15, -1), "R1 reverse A");
        // R2: alternating lanes from A and B
        c = '0;
        for (int i = 0; i < 16; i++) c[127-8*i -: 8] = 8'(((i & 1) << 4) | (15 - i));
        send(a, b, c, "R2 interleave A/B");
        // R9: broadcast one byte of B to all lanes
        send(a, b, fill_ctl(8'h13, 0), "R9 broadcast");
        // R3: upper bits set on identity B
        send(a, b, fill_ctl(16, 1) | {16{8'hE0}}, "R3 high bits ignored");

        // R6: single op, latency one, pulse one cycle
        @(negedge clk);
        send(rnd128(), rnd128(), rnd128(), "R2 single");
        check("R6 out_valid after op", 128'(out_valid), 128'(1));
        @(negedge clk);
        check("R6 out_valid drops", 128'(out_valid), 128'(0));
        // R7: value held while idle
        repeat (2) @(negedge clk);
        check("R7 hold result", result, last_exp);
        check("R7 idle valid", 128'(out_valid), 128'(0));

        // random back-to-back, plus same vectors with ignored bits set
        for (int n = 0; n < 150; n++) begin
            a = rnd128();
            b = rnd128();
            c = rnd128() & {16{8'h1F}};
            send(a, b, c, "R2 random");
            send(a, b, c | {16{8'hE0}}, "R3 random high bits");
        end
        @(negedge clk);
        check("R6 all results seen", 128'(exp_q.size()), 128'(0));

        // R8: reset mid-run
        send(rnd128(), rnd128(), rnd128(), "R2 pre-reset");
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid reset out_valid", 128'(out_valid), 128'(0));
        check("R8 mid reset result", result, '0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule